// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block looks at every interrupt source in a controller and picks, separately for each CPU, the one that should be presented to that CPU next. A source is a candidate for a CPU when that CPU has it enabled and pending. Sources with an ID of 32 or more must also have the CPU's bit set in their target mask. Among the candidates, the one with the smallest priority value wins. When two candidates have the same priority, the lower ID wins.

The winner's priority is then compared with two per-CPU thresholds. If it is strictly below the CPU's priority mask, its ID is reported on the highest-pending output. If it is also strictly below the CPU's running priority, the CPU's request line is raised. Software register access, acknowledge and end-of-interrupt handling sit outside this block. Their results arrive as plain state inputs, and the outputs are registered. Any input change appears at the outputs one clock edge later.

Top module: `hpsel_top`

## Requirements
- R1: A source is a candidate for CPU c only when both its enable bit and its pending bit for CPU c are set. A CPU with no candidate reports ID 1023 and keeps its request line low.
- R2: A source with ID 32 or above is a candidate for CPU c only if bit c of its target mask is set. Sources 0 to 31 ignore the target mask.
- R3: Among the candidates, the one with the numerically smallest 8-bit priority is the winner.
- R4: When several candidates share the smallest priority, the one with the lowest ID wins.
- R5: The highest-pending ID of CPU c is the winner's ID only if the winner's priority is strictly less than that CPU's 8-bit priority mask. Otherwise it is 1023, and a mask of 0 always gives 1023.
- R6: The request line of CPU c is high only when a winner is reported and its priority is also strictly less than the CPU's 9-bit running priority. A running priority of 256 means idle, so any reported winner then raises the line.
- R7: If both bits of the 2-bit distributor group enable are 0, or both bits of CPU c's 2-bit interface group enable are 0, then CPU c's request line is low and its highest-pending ID is 1023.
- R8: The outputs are registered and reflect the inputs present at the previous rising clock edge. During synchronous active-high reset and right after it, every request line is 0 and every highest-pending ID is 1023.
- R9: Each CPU's result depends only on that CPU's enables, pending bits, target-mask bit, mask, running priority and interface enable, together with the shared priorities and the distributor enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | NUM_CPU*NUM_SRC | Enable bit of source s for CPU c, at bit c*NUM_SRC+s |
| src_pend | input | NUM_CPU*NUM_SRC | Pending bit of source s for CPU c, at bit c*NUM_SRC+s |
| src_tgt | input | NUM_SRC*NUM_CPU | Target mask; bit s*NUM_CPU+c routes shared source s to CPU c |
| src_prio | input | NUM_SRC*PRIO_W | Priority of source s at bits [s*PRIO_W +: PRIO_W] |
| dist_grp_en | input | 2 | Distributor group enables |
| cpu_grp_en | input | NUM_CPU*2 | Interface group enables of CPU c at [c*2 +: 2] |
| cpu_mask | input | NUM_CPU*PRIO_W | Priority mask of CPU c |
| cpu_run | input | NUM_CPU*(PRIO_W+1) | Running priority of CPU c; 256 means idle |
| irq_req | output | NUM_CPU | Registered request line per CPU |
| hp_id | output | NUM_CPU*10 | Registered highest-pending ID of CPU c at [c*10 +: 10] |

## Verification
The hardest case to reach from the ports is a priority tie between sources in different subtrees of the selection tree. In that case only the strictness of each comparison keeps the lower ID in front. The stimulus creates ties between a private and a shared source, and between two widely separated shared IDs. It also places the winner's priority exactly equal to the mask and then exactly equal to the running priority, so each strict comparison is tested at the point where it flips. Per-CPU independence is checked by routing one shared source to only one CPU and by giving the two CPUs different private sources.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;
  localparam int ID_W        = 10;
  localparam int SPURIOUS_ID = 1023;
  localparam int PRIVATE_CNT = 32;
endpackage

// File: rtl/hpsel_tree.sv
module hpsel_tree #(
  parameter int N    = 64,
  parameter int PW   = 8,
  parameter int IW   = 10,
  localparam int P2  = 1 << $clog2(N),
  localparam int NODES = 2 * P2 - 1
) (
  input  logic [N*(PW+1)-1:0] leaf_prio,
  output logic [PW:0]         best_prio,
  output logic [IW-1:0]       best_id
);
  localparam logic [PW:0] IDLE = (PW+1)'(1) << PW;

  logic [PW:0]   node_p [NODES];
  logic [IW-1:0] node_i [NODES];

  for (genvar i = 0; i < P2; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node_p[P2-1+i] = leaf_prio[i*(PW+1) +: (PW+1)];
    end else begin : g_pad
      assign node_p[P2-1+i] = IDLE;
    end
    assign node_i[P2-1+i] = IW'(i);
  end

  for (genvar k = 0; k < P2 - 1; k++) begin : g_node
    logic take_right;
    assign take_right = node_p[2*k+2] < node_p[2*k+1];
    assign node_p[k]  = take_right ? node_p[2*k+2] : node_p[2*k+1];
    assign node_i[k]  = take_right ? node_i[2*k+2] : node_i[2*k+1];
  end

  assign best_prio = node_p[0];
  assign best_id   = node_i[0];
endmodule

// File: rtl/hpsel_cpu.sv
module hpsel_cpu
  import hpsel_pkg::*;
#(
  parameter int N  = 64,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    en,
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    tgt,
  input  logic [N*PW-1:0] prio,
  input  logic            gate_on,
  input  logic [PW-1:0]   mask,
  input  logic [PW:0]     run,
  output logic            irq,
  output logic [ID_W-1:0] hp
);
  localparam logic [PW:0] IDLE = (PW+1)'(1) << PW;

  logic [N*(PW+1)-1:0] leaf;
  logic [PW:0]         win_p;
  logic [ID_W-1:0]     win_i;

  for (genvar s = 0; s < N; s++) begin : g_q
    logic routed;
    if (s < PRIVATE_CNT) begin : g_priv
      assign routed = 1'b1;
    end else begin : g_shared
      assign routed = tgt[s];
    end
    assign leaf[s*(PW+1) +: (PW+1)] =
      (en[s] && pend[s] && routed) ? {1'b0, prio[s*PW +: PW]} : IDLE;
  end

  hpsel_tree #(.N(N), .PW(PW), .IW(ID_W)) u_tree (
    .leaf_prio (leaf),
    .best_prio (win_p),
    .best_id   (win_i)
  );

  logic vis, fire;
  assign vis  = gate_on && (win_p < {1'b0, mask});
  assign fire = vis && (win_p < run);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      hp  <= ID_W'(SPURIOUS_ID);
    end else begin
      irq <= fire;
      hp  <= vis ? win_i : ID_W'(SPURIOUS_ID);
    end
  end
endmodule

// File: rtl/hpsel_top.sv
module hpsel_top
  import hpsel_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CPU*NUM_SRC-1:0]  src_en,
  input  logic [NUM_CPU*NUM_SRC-1:0]  src_pend,
  input  logic [NUM_SRC*NUM_CPU-1:0]  src_tgt,
  input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
  input  logic [1:0]                  dist_grp_en,
  input  logic [NUM_CPU*2-1:0]        cpu_grp_en,
  input  logic [NUM_CPU*PRIO_W-1:0]   cpu_mask,
  input  logic [NUM_CPU*(PRIO_W+1)-1:0] cpu_run,
  output logic [NUM_CPU-1:0]          irq_req,
  output logic [NUM_CPU*ID_W-1:0]     hp_id
);
  initial begin
    if (NUM_SRC % 32 != 0 || NUM_CPU < 1 || NUM_CPU > 8)
      $error("hpsel_top: bad parameters");
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] tcol;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign tcol[s] = src_tgt[s*NUM_CPU + c];
    end

    hpsel_cpu #(.N(NUM_SRC), .PW(PRIO_W)) u_cpu (
      .clk     (clk),
      .rst     (rst),
      .en      (src_en[c*NUM_SRC +: NUM_SRC]),
      .pend    (src_pend[c*NUM_SRC +: NUM_SRC]),
      .tgt     (tcol),
      .prio    (src_prio),
      .gate_on ((|dist_grp_en) && (|cpu_grp_en[c*2 +: 2])),
      .mask    (cpu_mask[c*PRIO_W +: PRIO_W]),
      .run     (cpu_run[c*(PRIO_W+1) +: (PRIO_W+1)]),
      .irq     (irq_req[c]),
      .hp      (hp_id[c*ID_W +: ID_W])
    );
  end
endmodule

// File: rtl/hpsel_chk.sv
module hpsel_chk
  import hpsel_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CPU*NUM_SRC-1:0]  src_en,
  input logic [1:0]                  dist_grp_en,
  input logic [NUM_CPU*2-1:0]        cpu_grp_en,
  input logic [NUM_CPU*PRIO_W-1:0]   cpu_mask,
  input logic [NUM_CPU-1:0]          irq_req,
  input logic [NUM_CPU*ID_W-1:0]     hp_id
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assert_irq_has_id_R6: assert property (@(posedge clk) disable iff (rst)
      irq_req[c] |-> hp_id[c*ID_W +: ID_W] != ID_W'(SPURIOUS_ID));

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (rst)
      (dist_grp_en == 2'b00 || cpu_grp_en[c*2 +: 2] == 2'b00)
        |=> (!irq_req[c] && hp_id[c*ID_W +: ID_W] == ID_W'(SPURIOUS_ID)));

    assert_mask_zero_R5: assert property (@(posedge clk) disable iff (rst)
      cpu_mask[c*PRIO_W +: PRIO_W] == '0
        |=> hp_id[c*ID_W +: ID_W] == ID_W'(SPURIOUS_ID));

    assert_none_enabled_R1: assert property (@(posedge clk) disable iff (rst)
      src_en[c*NUM_SRC +: NUM_SRC] == '0
        |=> (!irq_req[c] && hp_id[c*ID_W +: ID_W] == ID_W'(SPURIOUS_ID)));

    assert_reset_idle_R8: assert property (@(posedge clk)
      rst |=> (!irq_req[c] && hp_id[c*ID_W +: ID_W] == ID_W'(SPURIOUS_ID)));
  end
endmodule

bind hpsel_top hpsel_chk #(
  .NUM_CPU (NUM_CPU),
  .NUM_SRC (NUM_SRC),
  .PRIO_W  (PRIO_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .src_en      (src_en),
  .dist_grp_en (dist_grp_en),
  .cpu_grp_en  (cpu_grp_en),
  .cpu_mask    (cpu_mask),
  .irq_req     (irq_req),
  .hp_id       (hp_id)
);

// File: tb/tb_hpsel_top.sv
`timescale 1ns/1ps
module tb_hpsel_top;
  localparam int NC = 2;
  localparam int NS = 64;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC*NS-1:0]   src_en   = '0;
  logic [NC*NS-1:0]   src_pend = '0;
  logic [NS*NC-1:0]   src_tgt  = '0;
  logic [NS*PW-1:0]   src_prio = '0;
  logic [1:0]         dist_grp_en = 2'b01;
  logic [NC*2-1:0]    cpu_grp_en  = '1;
  logic [NC*PW-1:0]   cpu_mask    = '1;
  logic [NC*(PW+1)-1:0] cpu_run;
  logic [NC-1:0]      irq_req;
  logic [NC*10-1:0]   hp_id;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hpsel_top #(.NUM_CPU(NC), .NUM_SRC(NS), .PRIO_W(PW)) dut (.*);

  task automatic chk(input int c, input bit eirq, input int ehp, input string req);
    int ahp;
    ahp = int'(hp_id[c*10 +: 10]);
    total++;
    if (irq_req[c] !== eirq || ahp != ehp) begin
      bad++;
      $display("FAIL %s cpu%0d: irq=%0b hp=%0d expected irq=%0b hp=%0d",
               req, c, irq_req[c], ahp, eirq, ehp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    src_en = '0; src_pend = '0; src_tgt = '0; src_prio = '0;
    dist_grp_en = 2'b01; cpu_grp_en = '1; cpu_mask = '1;
    for (int c = 0; c < NC; c++) cpu_run[c*9 +: 9] = 9'h100;
  endtask

  task automatic put(input int s, input int p, input bit e0, input bit e1,
                     input bit t0, input bit t1);
    src_prio[s*PW +: PW] = p[7:0];
    src_en[s] = e0; src_pend[s] = e0;
    src_en[NS+s] = e1; src_pend[NS+s] = e1;
    src_tgt[s*NC] = t0; src_tgt[s*NC+1] = t1;
  endtask

  task automatic t_reset();
    chk(0, 0, 1023, "R8"); chk(1, 0, 1023, "R8");
  endtask

  task automatic t_routing();
    clear_all();
    put(40, 8'h20, 1, 1, 1, 0);
    put(5, 8'h30, 0, 1, 0, 0);
    settle();
    chk(0, 1, 40, "R2");
    chk(1, 1, 5, "R2 R9");
  endtask

  task automatic t_qualify();
    clear_all();
    put(40, 8'h20, 1, 0, 1, 1);
    src_en[40] = 0;
    settle();
    chk(0, 0, 1023, "R1");
    src_en[40] = 1; src_pend[40] = 0;
    settle();
    chk(0, 0, 1023, "R1");
    src_pend[40] = 1;
    settle();
    chk(0, 1, 40, "R1");
  endtask

  task automatic t_lowest();
    clear_all();
    put(10, 8'h50, 1, 0, 1, 1);
    put(50, 8'h10, 1, 0, 1, 1);
    put(63, 8'h30, 1, 0, 1, 1);
    settle();
    chk(0, 1, 50, "R3");
  endtask

  task automatic t_tie();
    clear_all();
    put(33, 8'h40, 1, 0, 1, 0);
    put(60, 8'h40, 1, 0, 1, 0);
    settle();
    chk(0, 1, 33, "R4");
    put(35, 8'h00, 1, 0, 1, 0);
    put(2, 8'h00, 1, 0, 0, 0);
    settle();
    chk(0, 1, 2, "R4");
  endtask

  task automatic t_mask();
    clear_all();
    put(20, 8'h80, 1, 0, 0, 0);
    cpu_mask[7:0] = 8'h80;
    settle();
    chk(0, 0, 1023, "R5");
    cpu_mask[7:0] = 8'h81;
    settle();
    chk(0, 1, 20, "R5");
    cpu_mask[7:0] = 8'h00;
    put(20, 8'h00, 1, 0, 0, 0);
    settle();
    chk(0, 0, 1023, "R5");
  endtask

  task automatic t_running();
    clear_all();
    put(20, 8'h80, 1, 0, 0, 0);
    cpu_run[8:0] = 9'h080;
    settle();
    chk(0, 0, 20, "R6");
    cpu_run[8:0] = 9'h081;
    settle();
    chk(0, 1, 20, "R6");
    put(20, 8'hFF, 1, 0, 0, 0);
    cpu_run[8:0] = 9'h100;
    cpu_mask[7:0] = 8'hFF;
    settle();
    chk(0, 0, 1023, "R6");
    put(20, 8'hFE, 1, 0, 0, 0);
    settle();
    chk(0, 1, 20, "R6");
  endtask

  task automatic t_gate();
    clear_all();
    put(7, 8'h10, 1, 1, 0, 0);
    dist_grp_en = 2'b00;
    settle();
    chk(0, 0, 1023, "R7"); chk(1, 0, 1023, "R7");
    dist_grp_en = 2'b10;
    cpu_grp_en[3:2] = 2'b00;
    settle();
    chk(0, 1, 7, "R7"); chk(1, 0, 1023, "R7 R9");
    cpu_grp_en[3:2] = 2'b10;
    settle();
    chk(1, 1, 7, "R7");
  endtask

  task automatic t_latency();
    clear_all();
    settle();
    put(45, 8'h05, 1, 0, 1, 0);
    #1;
    chk(0, 0, 1023, "R8");
    settle();
    chk(0, 1, 45, "R8");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_all();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_routing();
    t_qualify();
    t_lowest();
    t_tie();
    t_mask();
    t_running();
    t_gate();
    t_latency();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule